// File: doc/BRIEF.md
# Multi-Mode PLL Phase Comparator

This block is the digital comparison stage of a frequency-multiplying phase-locked loop. A fast clock stands in for the oscillator output. It is divided down by a binary counter whose tap is chosen at run time, which gives a replica of the reference. The block then compares that replica with the reference input. The VCO, the loop filter and all analog behaviour lie outside it.

Three comparison methods share one pair of pump outputs and are chosen with `mode`:

- **Edge-sensitive phase-frequency method.** It asks for more frequency when the reference edge arrives first. It asks for less when the replica edge arrives first. When the two edges agree, it rests in a neutral, undriven state.
- **Exclusive-OR method.** It always drives one of the two pumps.
- **Set/reset latch method.** It also always drives one of the two pumps.

A lock flag follows the edge-sensitive method only. It rises once a programmable number of consecutive reference periods have passed without a correction pulse longer than one system clock.

Both asynchronous inputs pass through synchronizers into the system clock domain. All edges are taken from the synchronized samples.

Top module: `pd_multimode`

## Requirements
- R1: After reset, `pump_up`, `pump_dn`, `lock_flag` and `fb_out` are all 0.
- R2: `fb_out` is bit `tap_sel` of a counter of synchronized `vco_in` rising edges, so tap k divides by 2^(k+1). A `tap_sel` above DIV_W-1 selects the top bit.
- R3: In the edge-sensitive method (`mode` 00, and also 11), a reference rise that arrives before a replica rise produces the code {pump_up,pump_dn}=10. That code holds until the next replica rise.
- R4: In the edge-sensitive method, a replica rise that arrives before a reference rise produces the code 01. That code holds until the next reference rise. The method never moves directly between 10 and 01.
- R5: The code 00 is the neutral, undriven state. Coincident reference and replica rises leave the outputs at 00. The code 11 never appears in any mode.
- R6: With `mode`=01, `pump_up` equals the synchronized reference XOR `fb_out`, and `pump_dn` is its complement.
- R7: With `mode`=10, a latch is set by a high reference while `fb_out` is low, and reset by a high `fb_out` while the reference is low. It holds when both are high or both are low. `pump_up` shows the latch and `pump_dn` shows its complement. The latch resets to 0.
- R8: `lock_flag` rises once `lock_periods` (at least 1) consecutive reference periods have shown no edge-sensitive correction longer than one system clock. A one-cycle correction pulse does not break the count.
- R9: An edge-sensitive correction that lasts two or more cycles clears `lock_flag` on the next clock edge. It also restarts the period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| vco_in | input | 1 | Oscillator stand-in clock, asynchronous, slower than clk/2 |
| mode | input | 2 | Method: 00/11 edge-sensitive, 01 XOR, 10 latch |
| tap_sel | input | TAP_W | Divider tap (k gives divide by 2^(k+1)) |
| lock_periods | input | LOCK_W | Good reference periods required for lock |
| pump_up | output | 1 | Raise-frequency request |
| pump_dn | output | 1 | Lower-frequency request |
| lock_flag | output | 1 | Lock indicator |
| fb_out | output | 1 | Divided replica |

## Verification
The bench builds the block with DIV_W=6 and LOCK_W=4. With those values, the tap select is three bits wide, so the out-of-range taps 6 and 7 can be driven and the clamp to the top counter bit can be checked. A counter only six bits deep also lets every divide ratio be counted out in a few hundred cycles. The bench uses tap 0, so each pair of oscillator pulses produces exactly one replica rise. That gives cycle-exact control of the skew between reference and replica. This control is what reaches the coincident case, the one-cycle pulse that lock tolerates, and the long pulse that breaks lock.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        PD_MODE_EDGE  = 2'b00,
        PD_MODE_XOR   = 2'b01,
        PD_MODE_LATCH = 2'b10,
        PD_MODE_EDGE2 = 2'b11
    } pd_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    localparam pump_t PUMP_IDLE = '{up: 1'b0, dn: 1'b0};

endpackage

// File: rtl/pd_sync_edge.sv
module pd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sh[STAGES-1];
    assign rise  = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

endmodule

// File: rtl/pd_divider.sv
module pd_divider #(
    parameter int DIV_W = 12,
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             fb
);
    localparam int MAX_TAP = DIV_W - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    int unsigned tap_idx;

    always_comb begin
        st_d = st_q;
        if (step) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (int'(tap_sel) > MAX_TAP) tap_idx = MAX_TAP;
        else                         tap_idx = int'(tap_sel);
        fb = st_q.cnt[tap_idx];
    end

endmodule

// File: rtl/pd_detector.sv
module pd_detector
    import pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ref_lvl,
    input  logic       ref_rise,
    input  logic       rep_lvl,
    output pump_t      pump,
    output logic       edge_active
);
    typedef struct packed {
        pump_t edge_st;
        logic  xor_st;
        logic  latch_st;
        logic  rep_prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       rep_rise;
    pd_mode_e   mode_e;

    assign rep_rise = rep_lvl & ~st_q.rep_prev;
    assign mode_e   = pd_mode_e'(mode);

    always_comb begin
        st_d          = st_q;
        st_d.rep_prev = rep_lvl;

        // edge-sensitive: two sticky flags, cleared together when both set
        st_d.edge_st.up = st_q.edge_st.up | ref_rise;
        st_d.edge_st.dn = st_q.edge_st.dn | rep_rise;
        if (st_d.edge_st.up && st_d.edge_st.dn) st_d.edge_st = PUMP_IDLE;

        // exclusive-or of the two levels
        st_d.xor_st = ref_lvl ^ rep_lvl;

        // level latch: set by reference, reset by replica, hold otherwise
        if (ref_lvl && !rep_lvl)      st_d.latch_st = 1'b1;
        else if (rep_lvl && !ref_lvl) st_d.latch_st = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (mode_e)
            PD_MODE_XOR:   pump = '{up: st_q.xor_st,   dn: ~st_q.xor_st};
            PD_MODE_LATCH: pump = '{up: st_q.latch_st, dn: ~st_q.latch_st};
            default:       pump = st_q.edge_st;
        endcase
    end

    assign edge_active = st_q.edge_st.up | st_q.edge_st.dn;

endmodule

// File: rtl/pd_lock.sv
module pd_lock #(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_rise,
    input  logic              edge_active,
    input  logic [LOCK_W-1:0] lock_periods,
    output logic              lock
);
    typedef struct packed {
        logic              prev_act;
        logic              period_ok;
        logic [LOCK_W-1:0] good_cnt;
        logic              lock;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic        long_pulse;

    assign long_pulse = edge_active & st_q.prev_act;

    always_comb begin
        st_d          = st_q;
        st_d.prev_act = edge_active;
        if (ref_rise) begin
            st_d.period_ok = 1'b1;
            if (st_q.period_ok && !long_pulse) begin
                if (st_q.good_cnt != '1) st_d.good_cnt = st_q.good_cnt + 1'b1;
            end else begin
                st_d.good_cnt = '0;
            end
        end else if (long_pulse) begin
            st_d.period_ok = 1'b0;
            st_d.good_cnt  = '0;
        end
        st_d.lock = (st_d.good_cnt >= lock_periods);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev_act: 1'b0, period_ok: 1'b1, good_cnt: '0, lock: 1'b0};
        else        st_q <= st_d;
    end

    assign lock = st_q.lock;

endmodule

// File: rtl/pd_multimode.sv
module pd_multimode
    import pd_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int LOCK_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int TAP_W      = (DIV_W > 1) ? $clog2(DIV_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              vco_in,
    input  logic [1:0]        mode,
    input  logic [TAP_W-1:0]  tap_sel,
    input  logic [LOCK_W-1:0] lock_periods,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              lock_flag,
    output logic              fb_out
);
    logic  ref_lvl, ref_rise;
    logic  vco_lvl, vco_rise;
    logic  edge_active;
    pump_t pump;

    pd_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_in),
        .level(ref_lvl), .rise(ref_rise)
    );

    pd_sync_edge #(.STAGES(SYNC_STAGES)) u_vco_sync (
        .clk(clk), .rst_n(rst_n), .async_in(vco_in),
        .level(vco_lvl), .rise(vco_rise)
    );

    pd_divider #(.DIV_W(DIV_W), .TAP_W(TAP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .step(vco_rise),
        .tap_sel(tap_sel), .fb(fb_out)
    );

    pd_detector u_det (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ref_lvl(ref_lvl), .ref_rise(ref_rise), .rep_lvl(fb_out),
        .pump(pump), .edge_active(edge_active)
    );

    pd_lock #(.LOCK_W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise),
        .edge_active(edge_active), .lock_periods(lock_periods),
        .lock(lock_flag)
    );

    assign pump_up = pump.up;
    assign pump_dn = pump.dn;

endmodule

// File: rtl/pd_multimode_chk.sv
module pd_multimode_chk #(
    parameter int TAP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [TAP_W-1:0] tap_sel,
    input logic             pump_up,
    input logic             pump_dn,
    input logic             lock_flag,
    input logic             fb_out,
    input logic             vco_lvl,
    input logic             vco_rise
);
    logic is_edge;
    assign is_edge = (mode == 2'b00) || (mode == 2'b11);

    p_never_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    p_up_not_to_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && $past(is_edge) && $past(pump_up)) |-> !pump_dn);

    p_dn_not_to_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && $past(is_edge) && $past(pump_dn)) |-> !pump_up);

    p_long_pulse_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && $past(is_edge) &&
         ((pump_up && $past(pump_up)) || (pump_dn && $past(pump_dn)))) |=> !lock_flag);

    p_fb_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vco_rise && $stable(tap_sel)) |=> ($stable(fb_out) || !$stable(tap_sel)));

    p_fb_follows_vco_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fb_out) && $stable(tap_sel)) |-> $past(vco_lvl));

endmodule

bind pd_multimode pd_multimode_chk #(.TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tap_sel(tap_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .lock_flag(lock_flag),
    .fb_out(fb_out), .vco_lvl(vco_lvl), .vco_rise(vco_rise)
);

// File: tb/tb_pd_multimode.sv
module tb_pd_multimode;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 6;
    localparam int LOCK_W     = 4;
    localparam int TAP_W      = $clog2(DIV_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_in = 1'b0;
    logic              vco_in = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic [TAP_W-1:0]  tap_sel = '0;
    logic [LOCK_W-1:0] lock_periods = 4'd3;
    logic              pump_up, pump_dn, lock_flag, fb_out;

    int n_chk = 0;
    int n_fail = 0;
    int fb_rises = 0;
    bit fb_prev = 1'b0;
    bit seen_up = 1'b0;
    bit seen_dn = 1'b0;
    bit finished = 1'b0;

    pd_multimode #(.DIV_W(DIV_W), .LOCK_W(LOCK_W)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
        .mode(mode), .tap_sel(tap_sel), .lock_periods(lock_periods),
        .pump_up(pump_up), .pump_dn(pump_dn), .lock_flag(lock_flag),
        .fb_out(fb_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (fb_out && !fb_prev) fb_rises++;
        fb_prev = fb_out;
        if (pump_up) seen_up = 1'b1;
        if (pump_dn) seen_dn = 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_in = 1'b0; vco_in = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        fb_rises = 0; seen_up = 1'b0; seen_dn = 1'b0;
    endtask

    task automatic pulse_ref();
        ref_in = 1'b1; tick(1); ref_in = 1'b0; tick(1);
    endtask

    task automatic pulse_vco(input int n);
        for (int i = 0; i < n; i++) begin
            vco_in = 1'b1; tick(1); vco_in = 1'b0; tick(1);
        end
    endtask

    // one reference period at tap 0: replica rise aligned with a reference
    // rise of delay 'skew' cycles (0 means coincident after synchronization)
    task automatic ref_period(input int skew);
        for (int c = 0; c < 8; c++) begin
            vco_in = (c == 0) || (c == 2);
            ref_in = (c == 1 + skew);
            tick(1);
        end
        vco_in = 1'b0; ref_in = 1'b0;
        tick(4);
    endtask

    task automatic test_reset();
        mode = 2'b00; tap_sel = '0;
        do_reset();
        chk("R1 pump_up", pump_up, 0);
        chk("R1 pump_dn", pump_dn, 0);
        chk("R1 lock_flag", lock_flag, 0);
        chk("R1 fb_out", fb_out, 0);
    endtask

    task automatic test_divider();
        mode = 2'b00;
        tap_sel = 3'd0; do_reset();
        pulse_vco(5); tick(6);
        chk("R2 tap0 rises", fb_rises, 3);
        tap_sel = 3'd3; do_reset();
        pulse_vco(40); tick(6);
        chk("R2 tap3 rises", fb_rises, 3);
        chk("R2 tap3 level", fb_out, 1);
        tap_sel = 3'd7; do_reset();
        pulse_vco(40); tick(6);
        chk("R2 tap clamp rises", fb_rises, 1);
        chk("R2 tap clamp level", fb_out, 1);
    endtask

    task automatic test_edge(input logic [1:0] m);
        mode = m; tap_sel = '0; do_reset();
        pulse_ref(); tick(6);
        chk("R3 ref leads up", pump_up, 1);
        chk("R3 ref leads dn", pump_dn, 0);
        pulse_vco(1); tick(6);
        chk("R3 replica clears", {pump_up, pump_dn}, 0);
        pulse_vco(2); tick(6);
        chk("R4 replica leads up", pump_up, 0);
        chk("R4 replica leads dn", pump_dn, 1);
        pulse_ref(); tick(6);
        chk("R4 ref clears", {pump_up, pump_dn}, 0);
    endtask

    task automatic test_xor();
        mode = 2'b01; tap_sel = '0; do_reset();
        chk("R6 both low", {pump_up, pump_dn}, 1);
        ref_in = 1'b1; tick(6);
        chk("R6 ref high", {pump_up, pump_dn}, 2);
        pulse_vco(1); tick(6);
        chk("R6 both high", {pump_up, pump_dn}, 1);
        ref_in = 1'b0; tick(6);
        chk("R6 replica high", {pump_up, pump_dn}, 2);
    endtask

    task automatic test_latch();
        mode = 2'b10; tap_sel = '0; do_reset();
        chk("R7 reset state", {pump_up, pump_dn}, 1);
        pulse_ref(); tick(6);
        chk("R7 set holds", {pump_up, pump_dn}, 2);
        pulse_vco(1); tick(6);
        chk("R7 reset by replica", {pump_up, pump_dn}, 1);
        ref_in = 1'b1; tick(6);
        chk("R7 both high holds", {pump_up, pump_dn}, 1);
        ref_in = 1'b0; tick(2);
        pulse_vco(1); tick(6);
        chk("R7 both low holds", {pump_up, pump_dn}, 1);
        ref_in = 1'b1; tick(6);
        chk("R7 set again", {pump_up, pump_dn}, 2);
        ref_in = 1'b0; tick(2);
    endtask

    task automatic test_lock();
        mode = 2'b00; tap_sel = '0; lock_periods = 4'd3; do_reset();
        ref_period(0); ref_period(0);
        chk("R5 coincident no up", seen_up, 0);
        chk("R5 coincident no dn", seen_dn, 0);
        chk("R8 two periods no lock", lock_flag, 0);
        ref_period(0);
        chk("R8 three periods lock", lock_flag, 1);
        seen_dn = 1'b0;
        ref_period(1); ref_period(1);
        chk("R8 short pulse seen", seen_dn, 1);
        chk("R8 short pulse keeps lock", lock_flag, 1);
        seen_dn = 1'b0;
        ref_period(3);
        chk("R9 long pulse seen", seen_dn, 1);
        chk("R9 long pulse unlocks", lock_flag, 0);
        ref_period(0); ref_period(0);
        chk("R9 count restarted", lock_flag, 0);
        ref_period(0);
        chk("R9 relock", lock_flag, 1);
    endtask

    initial begin
        test_reset();
        test_divider();
        test_edge(2'b00);
        test_edge(2'b11);
        test_xor();
        test_latch();
        test_lock();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule